// File: doc/BRIEF.md
# Erased Sector Zero-Bit Screen

This block runs after a multi-bit error decoder has reported that a sector has more errors than it can correct. It looks at the same sector again to tell two cases apart. In the first case the sector was simply never programmed: an erased page reads back almost all ones, and its stored check bytes are all ones too, which is not a valid codeword. In the second case the sector is genuinely damaged. The bytes stream in one per cycle, each tagged as belonging to the data region (normally 512 bytes) or to the check-byte region (normally 13 bytes). The block counts the bits that read as zero in each region separately. A region's counter stops moving once it has gone past the correction limit of 8.

When the final byte is marked, the block adds the two region counts. If the total is within the limit, the sector is declared erased. The data-region count is then reported as the number of bits corrected. If that count is nonzero, the block raises a request for the surrounding logic to overwrite the whole data buffer with 0xFF; the block does not touch the buffer itself. If the total is above the limit, the sector is flagged as uncorrectable. The block does not count bytes, so the sector length is set only by where the last-byte marker falls.

The controller has three states:
- **IDLE**: waiting.
- **COUNT**: accumulating zero bits.
- **REPORT**: a one-cycle state that presents the verdict.

The transitions are:
- **go** (any state to COUNT): start is asserted.
- **finish** (COUNT to REPORT): a valid byte arrives with its last marker set.
- **retire** (REPORT to IDLE): the next cycle, with no start.

Top module: `erased_sector_check`

## Requirements
- R1: The zero count of a byte is the number of its bits equal to 0. That count is added to the region the byte is tagged with: `byte_ecc_i`=1 means the check-byte region and 0 means the data region.
- R2: Each region's count saturates. Once it exceeds 8 it holds at 9 for the rest of the sector, however many further zero bits arrive, and it never wraps.
- R3: If the check-byte count plus the data count is at most 8, the verdict is erased=1 and uncorrectable=0.
- R4: If that sum is 9 or more, the verdict is uncorrectable=1 and erased=0.
- R5: The fill request is 1 exactly when the verdict is erased and the data count is nonzero.
- R6: The corrected count equals the data-region zero count when the verdict is erased, and is 0 when it is uncorrectable.
- R7: `done_o` is high for exactly the one cycle after the clock edge that captured the valid last byte. The verdict outputs are valid only in that cycle. In all other cycles every output is 0.
- R8: Start clears both counts and begins a sector, even in the middle of a sector. A valid byte in the same cycle as start is ignored. Bytes that arrive, and last markers that are set, while no sector is open have no effect and produce no `done_o`.
- R9: A cycle with `byte_valid_i`=0 changes no count and does not end the sector, whatever the values on the byte, tag and last inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new sector and clears the counts |
| byte_valid_i | input | 1 | Qualifies the byte, tag and last inputs |
| byte_i | input | 8 | Sector byte |
| byte_ecc_i | input | 1 | 1 = check-byte region, 0 = data region |
| byte_last_i | input | 1 | Marks the final byte of the sector |
| done_o | output | 1 | One-cycle verdict strobe |
| erased_o | output | 1 | Sector judged erased |
| uncorr_o | output | 1 | Sector judged uncorrectable |
| fill_req_o | output | 1 | Request to rewrite the data buffer with 0xFF |
| corr_cnt_o | output | 4 | Reported corrected-bit count |

## Verification
The bench targets the sum boundary from both sides. A total of exactly 8 must still be judged erased, and 9 must flip the verdict, so an off-by-one comparison fails one of the two cases. Full sectors of 0x00 bytes produce thousands of zero bits; a counter that wraps instead of saturating would land on a small value and wrongly call those sectors erased. Sectors with all zeros in one region and none in the other catch a design that mixes up the region tags or that fills the buffer when the data count is zero. Restarts in mid-sector, stray bytes and last markers sent while idle, and invalid cycles carrying zero bytes each expose leaked counts or a spurious `done_o`.

// File: rtl/ezd_pkg.sv
package ezd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_REPORT = 2'd2
    } ezd_state_e;

endpackage

// File: rtl/ezd_zero_counter.sv
module ezd_zero_counter #(
    parameter int BYTE_W = 8,
    parameter int LIMIT  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [BYTE_W-1:0] din,
    output logic [CNT_W-1:0]  cnt
);
    localparam int SAT   = LIMIT + 1;
    localparam int PW    = $clog2(BYTE_W + 1);
    localparam int SUM_W = $clog2(LIMIT + BYTE_W + 1);

    logic [PW-1:0]    zeros;
    logic [SUM_W-1:0] sum;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            zeros = zeros + PW'(~din[i]);
        end
        sum = SUM_W'(cnt) + SUM_W'(zeros);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (add && (cnt <= CNT_W'(LIMIT))) begin
            cnt <= (sum > SUM_W'(LIMIT)) ? CNT_W'(SAT) : CNT_W'(sum);
        end
    end

    // R2: once past the limit, the count is frozen until cleared
    a_r2_frozen_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > CNT_W'(LIMIT) && !clear) |=> $stable(cnt));

    // R1: an accumulating byte never makes the count decrease
    a_r1_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clear) |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/ezd_verdict.sv
module ezd_verdict #(
    parameter int LIMIT = 8,
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] ecc_cnt,
    input  logic [CNT_W-1:0] data_cnt,
    output logic             erased,
    output logic             fill,
    output logic [CNT_W-1:0] corr
);
    logic [CNT_W:0] total;

    always_comb begin
        total  = {1'b0, ecc_cnt} + {1'b0, data_cnt};
        erased = (total <= (CNT_W+1)'(LIMIT));
        fill   = erased && (data_cnt != '0);
        corr   = erased ? data_cnt : '0;
    end

endmodule

// File: rtl/erased_sector_check.sv
module erased_sector_check
    import ezd_pkg::*;
#(
    parameter  int BYTE_W = 8,
    parameter  int LIMIT  = 8,
    localparam int CNT_W  = $clog2(LIMIT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_ecc_i,
    input  logic              byte_last_i,
    output logic              done_o,
    output logic              erased_o,
    output logic              uncorr_o,
    output logic              fill_req_o,
    output logic [CNT_W-1:0]  corr_cnt_o
);
    localparam int N_REG = 2;   // index 0: data region, index 1: check-byte region

    ezd_state_e       state_q, state_d;
    logic             take;
    logic [CNT_W-1:0] cnt   [N_REG];
    logic             v_erased, v_fill;
    logic [CNT_W-1:0] v_corr;

    assign take = (state_q == ST_COUNT) && byte_valid_i && !start_i;

    for (genvar g = 0; g < N_REG; g++) begin : g_region
        ezd_zero_counter #(
            .BYTE_W (BYTE_W),
            .LIMIT  (LIMIT),
            .CNT_W  (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (start_i),
            .add   (take && (byte_ecc_i == 1'(g))),
            .din   (byte_i),
            .cnt   (cnt[g])
        );
    end

    ezd_verdict #(
        .LIMIT (LIMIT),
        .CNT_W (CNT_W)
    ) u_verdict (
        .ecc_cnt  (cnt[1]),
        .data_cnt (cnt[0]),
        .erased   (v_erased),
        .fill     (v_fill),
        .corr     (v_corr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_COUNT;
            ST_COUNT:  if (start_i) state_d = ST_COUNT;
                       else if (byte_valid_i && byte_last_i) state_d = ST_REPORT;
            ST_REPORT: state_d = start_i ? ST_COUNT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        done_o     = 1'b0;
        erased_o   = 1'b0;
        uncorr_o   = 1'b0;
        fill_req_o = 1'b0;
        corr_cnt_o = '0;
        unique case (state_q)
            ST_REPORT: begin
                done_o     = 1'b1;
                erased_o   = v_erased;
                uncorr_o   = !v_erased;
                fill_req_o = v_fill;
                corr_cnt_o = v_corr;
            end
            default: ;
        endcase
    end

    // R7: done is a single-cycle strobe
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a captured last byte yields done on the next cycle
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (take && byte_last_i) |=> done_o);

    // R3/R4: exactly one verdict while done
    a_r4_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (erased_o ^ uncorr_o));

    // R5: a fill request only comes with an erased verdict and a nonzero count
    a_r5_fill_needs_erased: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o |-> (erased_o && corr_cnt_o != '0));

    // R6: an uncorrectable sector reports no corrected bits
    a_r6_uncorr_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_o |-> (corr_cnt_o == '0));

    // R7: outputs are quiet when no verdict is presented
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!erased_o && !uncorr_o && !fill_req_o && corr_cnt_o == '0));

endmodule

// File: tb/erased_sector_check_test.sv
module erased_sector_check_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       byte_ecc_i = 1'b0;
    logic       byte_last_i = 1'b0;
    logic       done_o, erased_o, uncorr_o, fill_req_o;
    logic [3:0] corr_cnt_o;

    always #2.5 clk = ~clk;   // 200 MHz

    erased_sector_check uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .byte_ecc_i(byte_ecc_i), .byte_last_i(byte_last_i),
        .done_o(done_o), .erased_o(erased_o), .uncorr_o(uncorr_o),
        .fill_req_o(fill_req_o), .corr_cnt_o(corr_cnt_o)
    );

    typedef struct {
        int    cyc;
        bit    er;
        bit    un;
        bit    fill;
        int    corr;
        string tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    bit         finished = 0;
    logic [7:0] dbuf [512];
    logic [7:0] ebuf [13];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each verdict against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_o) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R8: unexpected done, actual done=1 expected done=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (cyc != e.cyc || erased_o != e.er || uncorr_o != e.un ||
                        fill_req_o != e.fill || int'(corr_cnt_o) != e.corr) begin
                        errors++;
                        $display("FAIL %s: actual cyc=%0d er=%0d un=%0d fill=%0d corr=%0d expected cyc=%0d er=%0d un=%0d fill=%0d corr=%0d",
                                 e.tag, cyc, erased_o, uncorr_o, fill_req_o, corr_cnt_o,
                                 e.cyc, e.er, e.un, e.fill, e.corr);
                    end
                end
            end else if (erased_o || uncorr_o || fill_req_o || corr_cnt_o != 0) begin
                checks++;
                errors++;
                $display("FAIL R7: outputs active without done, actual er=%0d un=%0d fill=%0d corr=%0d expected all 0",
                         erased_o, uncorr_o, fill_req_o, corr_cnt_o);
            end
        end
    end

    task automatic fill_bufs(input logic [7:0] dv, input logic [7:0] ev);
        for (int i = 0; i < 512; i++) dbuf[i] = dv;
        for (int i = 0; i < 13; i++)  ebuf[i] = ev;
    endtask

    task automatic open_sector();
        @(negedge clk);
        start_i = 1'b1;
        byte_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // driver: computes the expected verdict from R1-style counting, then streams the bytes
    task automatic run_sector(input int nd, input int ne, input int gap,
                              input bit ecc_first, input string tag);
        int   zd, ze, sum, total, k;
        exp_t e;
        zd = 0; ze = 0;
        for (int i = 0; i < nd; i++) zd += $countones(~dbuf[i]);
        for (int i = 0; i < ne; i++) ze += $countones(~ebuf[i]);
        if (zd > 9) zd = 9;
        if (ze > 9) ze = 9;
        sum = zd + ze;
        e.er   = (sum <= 8);
        e.un   = (sum > 8);
        e.fill = e.er && (zd != 0);
        e.corr = e.er ? zd : 0;
        e.tag  = tag;
        open_sector();
        total = nd + ne;
        k = 0;
        for (int p = 0; p < 2; p++) begin
            bit region_ecc;
            int n;
            region_ecc = (p == 0) ? ecc_first : !ecc_first;
            n = region_ecc ? ne : nd;
            for (int i = 0; i < n; i++) begin
                if (k != 0) @(negedge clk);
                byte_valid_i = 1'b1;
                byte_i       = region_ecc ? ebuf[i] : dbuf[i];
                byte_ecc_i   = region_ecc;
                byte_last_i  = (k == total - 1);
                if (k == total - 1) begin
                    e.cyc = cyc + 1;
                    sb.push_back(e);
                end else begin
                    for (int g = 0; g < gap; g++) begin
                        @(negedge clk);
                        // R9: invalid cycles carry zero bytes and a last marker
                        byte_valid_i = 1'b0;
                        byte_i       = 8'h00;
                        byte_ecc_i   = ~byte_ecc_i;
                        byte_last_i  = 1'b1;
                    end
                end
                k++;
            end
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
        byte_last_i  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R7)
        checks++;
        if (done_o || erased_o || uncorr_o || fill_req_o || corr_cnt_o != 0) begin
            errors++;
            $display("FAIL R7: reset outputs actual done=%0d er=%0d un=%0d fill=%0d corr=%0d expected 0",
                     done_o, erased_o, uncorr_o, fill_req_o, corr_cnt_o);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: bytes and last marker while idle are ignored (monitor flags any done)
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            byte_valid_i = 1'b1; byte_i = 8'h00; byte_ecc_i = 1'b0; byte_last_i = (i == 3);
        end
        @(negedge clk);
        byte_valid_i = 1'b0; byte_last_i = 1'b0;
        repeat (3) @(negedge clk);

        // R3 R5: clean erased sector, no fill
        fill_bufs(8'hFF, 8'hFF);
        run_sector(512, 13, 0, 0, "R3 all-ones");

        // R1 R5 R6: 3 data zeros, 2 check zeros
        fill_bufs(8'hFF, 8'hFF);
        dbuf[100] = 8'hF8; ebuf[5] = 8'h7E;
        run_sector(512, 13, 0, 0, "R6 data3 ecc2");

        // R3 R6: boundary sum exactly 8, all in data
        fill_bufs(8'hFF, 8'hFF);
        dbuf[0] = 8'hF0; dbuf[511] = 8'h0F;
        run_sector(512, 13, 0, 0, "R3 sum8 data");

        // R5: 8 check zeros, data clean -> erased, no fill
        fill_bufs(8'hFF, 8'hFF);
        ebuf[12] = 8'h00;
        run_sector(512, 13, 0, 0, "R5 sum8 ecc");

        // R4: sum 9
        fill_bufs(8'hFF, 8'hFF);
        dbuf[7] = 8'hF0; ebuf[2] = 8'hE0;
        run_sector(512, 13, 0, 0, "R4 sum9");

        // R2: every bit zero in both regions must saturate, not wrap
        fill_bufs(8'h00, 8'h00);
        run_sector(512, 13, 0, 0, "R2 all-zero");

        // R2: data alone 4096 zeros, check clean
        fill_bufs(8'h00, 8'hFF);
        run_sector(512, 13, 0, 0, "R2 data-zero");

        // R4: check region 9 zeros, data clean
        fill_bufs(8'hFF, 8'hFF);
        ebuf[0] = 8'h00; ebuf[1] = 8'h7F;
        run_sector(512, 13, 0, 0, "R4 ecc9");

        // R9: short sector with invalid zero-byte bubbles
        fill_bufs(8'hFF, 8'hFF);
        dbuf[1] = 8'hFE;
        run_sector(6, 3, 2, 0, "R9 bubbles");

        // R1: check region sent first, tags honoured
        fill_bufs(8'hFF, 8'hFF);
        dbuf[3] = 8'hEF; ebuf[0] = 8'h3F;
        run_sector(16, 13, 0, 1, "R1 ecc-first");

        // R8: restart mid-sector clears counts
        open_sector();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            byte_valid_i = 1'b1; byte_i = 8'h00; byte_ecc_i = i[0]; byte_last_i = 1'b0;
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
        fill_bufs(8'hFF, 8'hFF);
        dbuf[2] = 8'h7F;
        run_sector(32, 13, 0, 0, "R8 restart");

        // R8: byte coincident with start is ignored
        @(negedge clk);
        start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h00; byte_ecc_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b0;
        fill_bufs(8'hFF, 8'hFF);
        begin
            exp_t e;
            @(negedge clk);
            byte_valid_i = 1'b1; byte_i = 8'hFF; byte_ecc_i = 1'b0; byte_last_i = 1'b1;
            e.cyc = cyc + 1; e.er = 1; e.un = 0; e.fill = 0; e.corr = 0; e.tag = "R8 start-byte";
            sb.push_back(e);
            @(negedge clk);
            byte_valid_i = 1'b0; byte_last_i = 1'b0;
            repeat (3) @(negedge clk);
        end

        // every expected verdict must have arrived (R7)
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R7: missing verdicts actual %0d pending expected 0", sb.size());
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule